// File: doc/BRIEF.md
# Multi-Thread Time-Slot Gate Scheduler

This block closes egress traffic-class gates on a time-triggered plan. A single shared table of time slots is split into contiguous index ranges. Up to eight execution threads each loop over one range. Every slot carries four fields: a duration counted in 200 ns deltas, a bitmap of the ports it applies to, a reserve enable, and a mask of the traffic classes it closes. While the scheduler runs, each active thread keeps one slot current. The block ORs the masks of all current slots into one closed-gate vector for each port.

Software loads the tables while the scheduler is stopped, over simple write strobes: the slot table, the per-thread entry table (start offset and entry address), the per-thread end-index table, and the active-thread count. It then raises `run`. A free-running count of elapsed deltas since the operational start arrives on `elapsed`, and `delta_tick` pulses once per delta. Each thread starts on its own offset and then cycles through its range without further intervention. Dropping `run` returns every thread to idle.

Top module: `gs_top`

## Requirements
- R1: Thread t takes part only when t <= the active-count register. That register holds the number of used threads minus one and resets to 0. Threads above the count never close a gate.
- R2: An enabled thread starts on the first `delta_tick` with `run` high at which `elapsed` is at least its entry delta. From that edge on, its current slot is its entry address.
- R3: The current slot of a running thread stays current for its duration in ticks. The next slot is index+1, except that after the thread's end index it wraps to its entry address. Ranges come from the end-index table, which is non-decreasing across threads; unused threads repeat the last used end index.
- R4: The 8 bits `gate_closed[p*8 +: 8]` of port p are the OR of the class masks of the current slots of all running threads whose port bitmap has bit p set and whose reserve enable is 1. A slot with reserve enable 0 closes nothing.
- R5: When `run` is low, every thread is idle and `gate_closed` is all zero from the next clock on. A later restart begins each thread again from its entry delta.
- R6: Any table or count write presented while `run` is high is ignored, and `wr_err` is 1 in the cycle after the write. An accepted write leaves `wr_err` 0.
- R7: A slot write with a duration of 0 or of at least MAX_DUR (200 by default) is ignored and flags `wr_err`. A duration of MAX_DUR-1 is accepted.
- R8: An entry-table write with a delta of 0 is ignored and flags `wr_err`. Entry deltas reset to 1.
- R9: After reset, `gate_closed` and `wr_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Scheduler running when high |
| delta_tick | input | 1 | One-cycle pulse per 200 ns delta |
| elapsed | input | 16 | Deltas elapsed since operational start |
| slot_we | input | 1 | Slot table write strobe |
| slot_addr | input | 4 | Slot index to write |
| slot_dur | input | 8 | Slot duration in deltas |
| slot_dst | input | 4 | Ports the slot applies to |
| slot_rm_en | input | 1 | Reserve enable of the slot |
| slot_mask | input | 8 | Traffic classes closed by the slot |
| ep_we | input | 1 | Entry table write strobe |
| ep_sel | input | 3 | Thread whose entry is written |
| ep_delta | input | 16 | Start offset in deltas (non-zero) |
| ep_addr | input | 4 | First slot index of the thread |
| end_we | input | 1 | End-index write strobe |
| end_sel | input | 3 | Thread whose end index is written |
| end_val | input | 4 | Last slot index of the thread |
| nact_we | input | 1 | Active-count write strobe |
| nact_val | input | 3 | Number of used threads minus one |
| gate_closed | output | 32 | Closed-class mask, 8 bits per port |
| wr_err | output | 1 | Rejected-write flag, one cycle |

## Verification
The first pattern has one thread looping over three slots of unequal length, which checks each slot's dwell time and the wrap from end back to entry. The second adds a later-starting thread on another range. One of its slots shares a port with the first thread, so the OR merge shows up. Another of its slots has its reserve enable cleared. A third thread is configured but lies beyond the active count. Writes issued while running, out-of-range durations and a zero entry delta are each followed by a run. Because the output then still follows the old tables, the bench can tell an ignored write from one that merely raised the flag.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic {
    TH_IDLE = 1'b0,
    TH_RUN  = 1'b1
  } th_state_e;
endpackage

// File: rtl/gs_cfg.sv
module gs_cfg #(
  parameter int NSLOT   = 16,
  parameter int NTHR    = 8,
  parameter int NP      = 4,
  parameter int NTC     = 8,
  parameter int DUR_W   = 8,
  parameter int MAX_DUR = 200,
  parameter int TW      = 16,
  localparam int AW     = $clog2(NSLOT),
  localparam int TIDW   = $clog2(NTHR)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           run,
  input  logic                           slot_we,
  input  logic [AW-1:0]                  slot_addr,
  input  logic [DUR_W-1:0]               slot_dur,
  input  logic [NP-1:0]                  slot_dst,
  input  logic                           slot_rm_en,
  input  logic [NTC-1:0]                 slot_mask,
  input  logic                           ep_we,
  input  logic [TIDW-1:0]                ep_sel,
  input  logic [TW-1:0]                  ep_delta_in,
  input  logic [AW-1:0]                  ep_addr_in,
  input  logic                           end_we,
  input  logic [TIDW-1:0]                end_sel,
  input  logic [AW-1:0]                  end_val,
  input  logic                           nact_we,
  input  logic [TIDW-1:0]                nact_val,
  output logic [NSLOT-1:0][DUR_W-1:0]    dur_tbl,
  output logic [NSLOT-1:0][NP-1:0]       dst_tbl,
  output logic [NSLOT-1:0]               rm_tbl,
  output logic [NSLOT-1:0][NTC-1:0]      mask_tbl,
  output logic [NTHR-1:0][TW-1:0]        ep_delta,
  output logic [NTHR-1:0][AW-1:0]        ep_addr,
  output logic [NTHR-1:0][AW-1:0]        end_idx,
  output logic [TIDW-1:0]                nact,
  output logic                           wr_err
);
  localparam logic [DUR_W:0] DUR_LIM = (DUR_W+1)'(MAX_DUR);

  logic slot_ok, ep_ok, end_ok, nact_ok, err_d;

  // Accept checks: stopped scheduler plus legal field values
  always_comb begin
    slot_ok = slot_we && !run && (slot_dur != '0) && ({1'b0, slot_dur} < DUR_LIM);
    ep_ok   = ep_we && !run && (ep_delta_in != '0);
    end_ok  = end_we && !run;
    nact_ok = nact_we && !run;
    err_d   = (slot_we && !slot_ok) || (ep_we && !ep_ok) ||
              (end_we && !end_ok) || (nact_we && !nact_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dur_tbl  <= '0;
      dst_tbl  <= '0;
      rm_tbl   <= '0;
      mask_tbl <= '0;
    end else if (slot_ok) begin
      dur_tbl[slot_addr]  <= slot_dur;
      dst_tbl[slot_addr]  <= slot_dst;
      rm_tbl[slot_addr]   <= slot_rm_en;
      mask_tbl[slot_addr] <= slot_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTHR; i++) begin
        ep_delta[i] <= TW'(1);
        ep_addr[i]  <= '0;
      end
    end else if (ep_ok) begin
      ep_delta[ep_sel] <= ep_delta_in;
      ep_addr[ep_sel]  <= ep_addr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_idx <= '0;
    end else if (end_ok) begin
      end_idx[end_sel] <= end_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nact   <= '0;
      wr_err <= 1'b0;
    end else begin
      if (nact_ok) nact <= nact_val;
      wr_err <= err_d;
    end
  end
endmodule

// File: rtl/gs_thread.sv
module gs_thread
  import gs_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int DUR_W = 8,
  parameter int TW    = 16,
  localparam int AW   = $clog2(NSLOT)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        run,
  input  logic                        tick,
  input  logic                        en_thr,
  input  logic [TW-1:0]               elapsed,
  input  logic [TW-1:0]               start_delta,
  input  logic [AW-1:0]               entry_addr,
  input  logic [AW-1:0]               last_addr,
  input  logic [NSLOT-1:0][DUR_W-1:0] dur_tbl,
  output logic                        active,
  output logic [AW-1:0]               idx
);
  th_state_e        st_q, st_d;
  logic [AW-1:0]    idx_q, idx_d, nxt;
  logic [DUR_W-1:0] cnt_q, cnt_d;
  logic             upd;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    cnt_d = cnt_q;
    nxt   = (idx_q == last_addr) ? entry_addr : idx_q + 1'b1;
    upd   = !run || tick;
    if (!run) begin
      st_d = TH_IDLE;
    end else if (st_q == TH_IDLE) begin
      if (en_thr && (elapsed >= start_delta)) begin
        st_d  = TH_RUN;
        idx_d = entry_addr;
        cnt_d = dur_tbl[entry_addr];
      end
    end else if (cnt_q <= DUR_W'(1)) begin
      idx_d = nxt;
      cnt_d = dur_tbl[nxt];
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TH_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      st_q  <= st_d;
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end

  assign active = (st_q == TH_RUN);
  assign idx    = idx_q;
endmodule

// File: rtl/gs_merge.sv
module gs_merge #(
  parameter int NTHR  = 8,
  parameter int NSLOT = 16,
  parameter int NP    = 4,
  parameter int NTC   = 8,
  localparam int AW   = $clog2(NSLOT)
) (
  input  logic [NTHR-1:0]            th_act,
  input  logic [NTHR-1:0][AW-1:0]    th_idx,
  input  logic [NSLOT-1:0][NP-1:0]   dst_tbl,
  input  logic [NSLOT-1:0]           rm_tbl,
  input  logic [NSLOT-1:0][NTC-1:0]  mask_tbl,
  output logic [NP-1:0][NTC-1:0]     gate
);
  always_comb begin
    gate = '0;
    for (int t = 0; t < NTHR; t++) begin
      for (int p = 0; p < NP; p++) begin
        if (th_act[t] && rm_tbl[th_idx[t]] && dst_tbl[th_idx[t]][p])
          gate[p] = gate[p] | mask_tbl[th_idx[t]];
      end
    end
  end
endmodule

// File: rtl/gs_top.sv
module gs_top #(
  parameter int NTHR    = 8,
  parameter int NSLOT   = 16,
  parameter int NP      = 4,
  parameter int NTC     = 8,
  parameter int DUR_W   = 8,
  parameter int MAX_DUR = 200,
  parameter int TW      = 16,
  localparam int AW     = $clog2(NSLOT),
  localparam int TIDW   = $clog2(NTHR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              delta_tick,
  input  logic [TW-1:0]     elapsed,
  input  logic              slot_we,
  input  logic [AW-1:0]     slot_addr,
  input  logic [DUR_W-1:0]  slot_dur,
  input  logic [NP-1:0]     slot_dst,
  input  logic              slot_rm_en,
  input  logic [NTC-1:0]    slot_mask,
  input  logic              ep_we,
  input  logic [TIDW-1:0]   ep_sel,
  input  logic [TW-1:0]     ep_delta,
  input  logic [AW-1:0]     ep_addr,
  input  logic              end_we,
  input  logic [TIDW-1:0]   end_sel,
  input  logic [AW-1:0]     end_val,
  input  logic              nact_we,
  input  logic [TIDW-1:0]   nact_val,
  output logic [NP*NTC-1:0] gate_closed,
  output logic              wr_err
);
  logic [NSLOT-1:0][DUR_W-1:0] dur_tbl;
  logic [NSLOT-1:0][NP-1:0]    dst_tbl;
  logic [NSLOT-1:0]            rm_tbl;
  logic [NSLOT-1:0][NTC-1:0]   mask_tbl;
  logic [NTHR-1:0][TW-1:0]     c_delta;
  logic [NTHR-1:0][AW-1:0]     c_addr;
  logic [NTHR-1:0][AW-1:0]     c_end;
  logic [TIDW-1:0]             nact;
  logic [NTHR-1:0]             th_act;
  logic [NTHR-1:0][AW-1:0]     th_idx;
  logic [NP-1:0][NTC-1:0]      gate;

  gs_cfg #(
    .NSLOT(NSLOT), .NTHR(NTHR), .NP(NP), .NTC(NTC),
    .DUR_W(DUR_W), .MAX_DUR(MAX_DUR), .TW(TW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .run(run),
    .slot_we(slot_we), .slot_addr(slot_addr), .slot_dur(slot_dur),
    .slot_dst(slot_dst), .slot_rm_en(slot_rm_en), .slot_mask(slot_mask),
    .ep_we(ep_we), .ep_sel(ep_sel), .ep_delta_in(ep_delta), .ep_addr_in(ep_addr),
    .end_we(end_we), .end_sel(end_sel), .end_val(end_val),
    .nact_we(nact_we), .nact_val(nact_val),
    .dur_tbl(dur_tbl), .dst_tbl(dst_tbl), .rm_tbl(rm_tbl), .mask_tbl(mask_tbl),
    .ep_delta(c_delta), .ep_addr(c_addr), .end_idx(c_end), .nact(nact),
    .wr_err(wr_err)
  );

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    gs_thread #(.NSLOT(NSLOT), .DUR_W(DUR_W), .TW(TW)) u_thr (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(delta_tick),
      .en_thr(TIDW'(t) <= nact), .elapsed(elapsed),
      .start_delta(c_delta[t]), .entry_addr(c_addr[t]), .last_addr(c_end[t]),
      .dur_tbl(dur_tbl), .active(th_act[t]), .idx(th_idx[t])
    );
  end

  gs_merge #(.NTHR(NTHR), .NSLOT(NSLOT), .NP(NP), .NTC(NTC)) u_merge (
    .th_act(th_act), .th_idx(th_idx), .dst_tbl(dst_tbl),
    .rm_tbl(rm_tbl), .mask_tbl(mask_tbl), .gate(gate)
  );

  assign gate_closed = gate;
endmodule

// File: rtl/gs_checker.sv
module gs_checker #(
  parameter int NTHR  = 8,
  parameter int NSLOT = 16,
  parameter int NP    = 4,
  parameter int NTC   = 8,
  parameter int TW    = 16,
  localparam int AW   = $clog2(NSLOT),
  localparam int TIDW = $clog2(NTHR)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     run,
  input logic                     delta_tick,
  input logic [TW-1:0]            elapsed,
  input logic                     any_we,
  input logic [NP*NTC-1:0]        gate_closed,
  input logic                     wr_err,
  input logic [NTHR-1:0]          th_act,
  input logic [NTHR-1:0][AW-1:0]  th_idx,
  input logic [NTHR-1:0][TW-1:0]  c_delta,
  input logic [NTHR-1:0][AW-1:0]  c_addr,
  input logic [NTHR-1:0][AW-1:0]  c_end,
  input logic [TIDW-1:0]          nact
);
  assert_run_write_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run && any_we |=> wr_err);

  assert_stop_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> gate_closed == '0);

  for (genvar t = 0; t < NTHR; t++) begin : g_chk
    assert_start_cond_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(th_act[t]) |-> $past(run && delta_tick && (elapsed >= c_delta[t])));

    assert_count_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(th_act[t]) |-> $past(TIDW'(t) <= nact));

    assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      th_act[t] |-> (th_idx[t] >= c_addr[t]) && (th_idx[t] <= c_end[t]));

    assert_idx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      th_act[t] && $past(th_act[t]) && !$past(delta_tick) |-> $stable(th_idx[t]));

    assert_delta_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      c_delta[t] != '0);
  end
endmodule

bind gs_top gs_checker #(.NTHR(NTHR), .NSLOT(NSLOT), .NP(NP), .NTC(NTC), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .delta_tick(delta_tick), .elapsed(elapsed),
  .any_we(slot_we || ep_we || end_we || nact_we),
  .gate_closed(gate_closed), .wr_err(wr_err),
  .th_act(th_act), .th_idx(th_idx), .c_delta(c_delta), .c_addr(c_addr),
  .c_end(c_end), .nact(nact)
);

// File: tb/tb_gs_top.sv
module tb_gs_top;
  localparam int NP = 4;
  localparam int NTC = 8;
  localparam int NSLOT = 16;
  localparam int NTHR = 8;
  localparam int MAX_DUR = 200;

  logic clk = 1'b0;
  logic rst_n;
  logic run, delta_tick, slot_we, slot_rm_en, ep_we, end_we, nact_we;
  logic [15:0] elapsed, ep_delta;
  logic [3:0] slot_addr, slot_dst, ep_addr, end_val;
  logic [7:0] slot_dur, slot_mask;
  logic [2:0] ep_sel, end_sel, nact_val;
  logic [NP*NTC-1:0] gate_closed;
  logic wr_err;

  int n_chk = 0;
  int n_fail = 0;
  int ecnt = 0;
  bit done = 0;

  // Bench copy of the tables, updated only by accepted writes
  int b_dur[NSLOT];
  logic [NP-1:0] b_dst[NSLOT];
  bit b_rm[NSLOT];
  logic [NTC-1:0] b_mask[NSLOT];
  int b_delta[NTHR];
  int b_addr[NTHR];
  int b_end[NTHR];
  int b_nact = 0;

  always #2 clk = ~clk;

  gs_top dut (
    .clk(clk), .rst_n(rst_n), .run(run), .delta_tick(delta_tick), .elapsed(elapsed),
    .slot_we(slot_we), .slot_addr(slot_addr), .slot_dur(slot_dur), .slot_dst(slot_dst),
    .slot_rm_en(slot_rm_en), .slot_mask(slot_mask),
    .ep_we(ep_we), .ep_sel(ep_sel), .ep_delta(ep_delta), .ep_addr(ep_addr),
    .end_we(end_we), .end_sel(end_sel), .end_val(end_val),
    .nact_we(nact_we), .nact_val(nact_val),
    .gate_closed(gate_closed), .wr_err(wr_err)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NP*NTC-1:0] exp_gate(int n);
    logic [NP*NTC-1:0] g = '0;
    for (int t = 0; t <= b_nact; t++) begin
      if (n >= b_delta[t]) begin
        int len = 0;
        int r;
        int s;
        for (int k = b_addr[t]; k <= b_end[t]; k++) len += b_dur[k];
        r = (n - b_delta[t]) % len;
        s = b_addr[t];
        while (r >= b_dur[s]) begin
          r -= b_dur[s];
          s++;
        end
        if (b_rm[s])
          for (int p = 0; p < NP; p++)
            if (b_dst[s][p]) g[p*NTC +: NTC] = g[p*NTC +: NTC] | b_mask[s];
      end
    end
    return g;
  endfunction

  task automatic wr_slot(string tag, int a, int d, logic [3:0] dst, bit rm, logic [7:0] m);
    bit ok = !run && d != 0 && d < MAX_DUR;
    slot_we = 1; slot_addr = 4'(a); slot_dur = 8'(d);
    slot_dst = dst; slot_rm_en = rm; slot_mask = m;
    @(negedge clk);
    slot_we = 0;
    check(tag, 64'(wr_err), 64'(!ok));
    if (ok) begin b_dur[a] = d; b_dst[a] = dst; b_rm[a] = rm; b_mask[a] = m; end
  endtask

  task automatic wr_ep(string tag, int t, int dl, int a);
    bit ok = !run && dl != 0;
    ep_we = 1; ep_sel = 3'(t); ep_delta = 16'(dl); ep_addr = 4'(a);
    @(negedge clk);
    ep_we = 0;
    check(tag, 64'(wr_err), 64'(!ok));
    if (ok) begin b_delta[t] = dl; b_addr[t] = a; end
  endtask

  task automatic wr_end(string tag, int t, int e);
    bit ok = !run;
    end_we = 1; end_sel = 3'(t); end_val = 4'(e);
    @(negedge clk);
    end_we = 0;
    check(tag, 64'(wr_err), 64'(!ok));
    if (ok) b_end[t] = e;
  endtask

  task automatic wr_nact(string tag, int v);
    bit ok = !run;
    nact_we = 1; nact_val = 3'(v);
    @(negedge clk);
    nact_we = 0;
    check(tag, 64'(wr_err), 64'(!ok));
    if (ok) b_nact = v;
  endtask

  task automatic tick_chk(string tag);
    delta_tick = 1; elapsed = 16'(ecnt);
    @(negedge clk);
    delta_tick = 0;
    check(tag, 64'(gate_closed), 64'(exp_gate(ecnt)));
    ecnt++;
  endtask

  task automatic start_run();
    run = 1; ecnt = 0; elapsed = 0;
    @(negedge clk);
  endtask

  task automatic stop_run(string tag);
    run = 0;
    @(negedge clk);
    check(tag, 64'(gate_closed), 64'(0));
  endtask

  task automatic t_reset();
    check("R9 gate after reset", 64'(gate_closed), 64'(0));
    check("R9 wr_err after reset", 64'(wr_err), 64'(0));
  endtask

  task automatic t_single();
    wr_slot("R6 accepted slot", 0, 2, 4'b0001, 1, 8'h0F);
    wr_slot("R6 accepted slot", 1, 3, 4'b0001, 1, 8'hF0);
    wr_slot("R6 accepted slot", 2, 1, 4'b0011, 1, 8'h81);
    wr_ep("R6 accepted entry", 0, 1, 0);
    for (int t = 0; t < NTHR; t++) wr_end("R6 accepted end", t, 2);
    wr_nact("R6 accepted count", 0);
    start_run();
    for (int i = 0; i < 14; i++) tick_chk("R2 R3 R4 single thread loop");
    stop_run("R5 stop clears gates");
  endtask

  task automatic t_dual();
    wr_slot("R6 accepted slot", 3, 2, 4'b0001, 1, 8'h30);
    wr_slot("R6 accepted slot", 4, 3, 4'b0100, 0, 8'hFF);
    wr_ep("R6 accepted entry", 1, 3, 3);
    wr_ep("R6 accepted entry", 2, 1, 3);
    for (int t = 1; t < NTHR; t++) wr_end("R6 accepted end", t, 4);
    wr_nact("R6 accepted count", 1);
    start_run();
    for (int i = 0; i < 16; i++) tick_chk("R1 R4 two threads merged, reserve off");
    stop_run("R5 stop clears gates");
  endtask

  task automatic t_run_write();
    start_run();
    for (int i = 0; i < 3; i++) tick_chk("R5 restart from entry delta");
    wr_slot("R6 slot write while running", 0, 5, 4'b1111, 1, 8'hAA);
    wr_ep("R6 entry write while running", 0, 7, 1);
    wr_end("R6 end write while running", 0, 1);
    wr_nact("R6 count write while running", 2);
    for (int i = 0; i < 10; i++) tick_chk("R6 tables unchanged after running write");
    stop_run("R5 stop clears gates");
  endtask

  task automatic t_bad_values();
    wr_slot("R7 zero duration", 1, 0, 4'b1000, 1, 8'h01);
    wr_slot("R7 duration at limit", 1, MAX_DUR, 4'b1000, 1, 8'h01);
    wr_slot("R7 duration below limit", 6, MAX_DUR - 1, 4'b1000, 1, 8'h01);
    wr_ep("R8 zero entry delta", 0, 0, 2);
    start_run();
    for (int i = 0; i < 12; i++) tick_chk("R7 R8 rejected values left tables unchanged");
    stop_run("R5 stop clears gates");
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; run = 0; delta_tick = 0; elapsed = 0;
    slot_we = 0; slot_addr = 0; slot_dur = 0; slot_dst = 0; slot_rm_en = 0; slot_mask = 0;
    ep_we = 0; ep_sel = 0; ep_delta = 0; ep_addr = 0;
    end_we = 0; end_sel = 0; end_val = 0; nact_we = 0; nact_val = 0;
    for (int i = 0; i < NSLOT; i++) begin b_dur[i] = 0; b_dst[i] = 0; b_rm[i] = 0; b_mask[i] = 0; end
    for (int t = 0; t < NTHR; t++) begin b_delta[t] = 1; b_addr[t] = 0; b_end[t] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_dual();
    t_run_write();
    t_bad_values();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule